// File: doc/BRIEF.md
# Rate-Generator Timer Channel

This block is one 16-bit down-counting timer channel that divides a one-cycle clock enable (`tick_en`) into a periodic output. Each output period is N ticks long, and the output goes low for one tick of each period. Software programs the channel through two byte-wide write strobes that share one data bus. One strobe writes a control word and the other writes a count byte. The control word names the target channel, the byte access order and the counting mode. The count strobe delivers the divisor N in the chosen byte order.

Only the rate-generator mode with binary counting is built. A control word that asks for anything else has no effect. The same holds for a word aimed at another channel and for the latch command. A typical use is a system tick. For a 1000 Hz tick from a 1193182 Hz enable, the divisor is the rate ratio rounded to nearest, which is 1193. It is loaded as control word 0x34 and then count bytes 0xA9 and 0x04.

Top module: `tmr_rate_channel`

## Requirements
- R1: After reset the output is high and the counter is stopped, whatever `tick_en` does. Until a control word is accepted, the count port uses low-then-high byte order.
- R2: The control word fields are: [7:6] channel, [5:4] access (01 low only, 10 high only, 11 low then high, 00 latch), [3:1] mode, and [0] BCD. A word is accepted only when all of these hold: [7:6] equals `CHAN_SEL`, access is not 00, mode is 010 or 110, and bit 0 is 0. Any other word leaves the running output pattern unchanged.
- R3: An accepted control word stops the counter at the next edge, and the output stays high. The word also returns the byte order to its first byte. The counter stays stopped until a complete divisor has been written.
- R4: In access 11 the first count write is the low byte and the second is the high byte. In access 01 a single write sets the low byte and the high byte is 0. In access 10 a single write sets the high byte and the low byte is 0.
- R5: The clock edge that captures the completing count write loads the counter with the divisor. Each later edge with `tick_en` high decrements it.
- R6: The output is low while the count is 1 and high otherwise. On the tick at count 1 the counter reloads the divisor, so the output is low for one tick in every N ticks.
- R7: A divisor of 0 gives a period of 65536 ticks.
- R8: While `tick_en` is low the count holds and the output does not change.
- R9: A divisor completed while the channel runs does not disturb the current period and takes effect at the next reload. If the completing write falls on the reload tick, the new divisor is the one loaded.
- R10: When both strobes are high in the same cycle, the control word is handled and the count write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counting enable, one count per cycle it is high |
| ctl_we | input | 1 | Control word write strobe |
| cnt_we | input | 1 | Count byte write strobe |
| wr_data | input | 8 | Write data shared by both strobes |
| tmr_out | output | 1 | Rate output, low for one tick per period |

## Verification
Two events can fall on the same edge: the reload at count 1, and the write that completes a new divisor. The bench times the high-byte write onto the reload tick of a running divisor-5 sequence. It then expects the new divisor 3 to govern the very next period, and it checks this cycle by cycle. A second case places the completing write early in a period and expects the old period to finish before the new length appears. A control-word write and a count write are also issued together, and the bench expects the output to stay high until a fresh divisor arrives.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } acc_e;

  typedef struct packed {
    logic [1:0] chan;
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } ctl_word_t;

  // A word is usable when it targets this channel, names a byte order,
  // selects the rate generator (x10) and binary counting.
  function automatic logic word_usable(ctl_word_t w, logic [1:0] own_chan);
    return (w.chan == own_chan) && (w.acc != ACC_LATCH) &&
           (w.mode[1:0] == 2'b10) && !w.bcd;
  endfunction

endpackage

// File: rtl/tmr_ctrl_port.sv
module tmr_ctrl_port
  import tmr_pkg::*;
#(
  parameter logic [1:0] CHAN_SEL = 2'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              ctl_accept,
  output acc_e              acc_mode
);

  ctl_word_t word;
  acc_e      acc_q;

  assign word       = ctl_word_t'(wr_data);
  assign ctl_accept = ctl_we && word_usable(word, CHAN_SEL);
  assign acc_mode   = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= ACC_LOHI;
    else if (ctl_accept) acc_q <= word.acc;
  end

  // R2: a strobe with a BCD word is never accepted
  p_no_bcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && wr_data[0]) |=> (acc_q == $past(acc_q)));

endmodule

// File: rtl/tmr_byte_loader.sv
module tmr_byte_loader
  import tmr_pkg::*;
#(
  parameter int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_accept,
  input  acc_e              acc_mode,
  input  logic              cnt_we,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              div_commit,
  output logic [CNT_W-1:0]  div_value
);

  localparam int HI_W = CNT_W - BYTE_W;

  logic              hi_next_q;
  logic [BYTE_W-1:0] low_q;
  logic              wr_live;

  function automatic logic [CNT_W-1:0] join_bytes(logic [HI_W-1:0] hi,
                                                  logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  assign wr_live = cnt_we && !ctl_accept;

  always_comb begin
    div_commit = 1'b0;
    div_value  = '0;
    if (wr_live) begin
      unique case (acc_mode)
        ACC_LO: begin
          div_commit = 1'b1;
          div_value  = join_bytes('0, wr_data);
        end
        ACC_HI: begin
          div_commit = 1'b1;
          div_value  = join_bytes(HI_W'(wr_data), '0);
        end
        ACC_LOHI: begin
          div_commit = hi_next_q;
          div_value  = join_bytes(HI_W'(wr_data), low_q);
        end
        default: div_commit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_next_q <= 1'b0;
      low_q     <= '0;
    end else if (ctl_accept) begin
      hi_next_q <= 1'b0;
    end else if (wr_live && acc_mode == ACC_LOHI) begin
      if (!hi_next_q) low_q <= wr_data;
      hi_next_q <= !hi_next_q;
    end
  end

  // R3: an accepted control word returns the order to the first byte
  p_order_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_accept |=> !hi_next_q);

  // R4: in paired order a commit is always the second of two writes
  p_pair_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_commit && acc_mode == ACC_LOHI) |=> !hi_next_q);

  // R10: a count write in the same cycle as an accepted word commits nothing
  p_ctl_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we && ctl_accept) |-> !div_commit);

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             stop_req,
  input  logic             load_req,
  input  logic [CNT_W-1:0] load_val,
  output logic             running,
  output logic             reload_evt,
  output logic             tmr_out
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, div_q, reload_src;
  logic             run_q, at_one, tick_live;

  // Wrap-around subtraction makes a zero divisor last 2**CNT_W ticks.
  function automatic logic [CNT_W-1:0] step(logic [CNT_W-1:0] cur,
                                            logic [CNT_W-1:0] rl,
                                            logic end_of_period);
    return end_of_period ? rl : cur - ONE;
  endfunction

  assign at_one     = (cnt_q == ONE);
  assign tick_live  = run_q && tick_en && !stop_req;
  assign reload_evt = tick_live && at_one;
  assign reload_src = load_req ? load_val : div_q;
  assign running    = run_q;
  assign tmr_out    = !(run_q && at_one);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      div_q <= '0;
    end else if (stop_req) begin
      run_q <= 1'b0;
    end else begin
      if (load_req) div_q <= load_val;
      if (!run_q && load_req) begin
        cnt_q <= load_val;
        run_q <= 1'b1;
      end else if (tick_live) begin
        cnt_q <= step(cnt_q, reload_src, at_one);
      end
    end
  end

  // R3: an accepted control word halts counting
  p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !run_q);

  // R5: the completing write starts the counter with its divisor
  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !run_q && !stop_req) |=> (run_q && cnt_q == $past(load_val)));

  // R6: away from count 1 every tick lowers the count by one
  p_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_live && !at_one && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

  // R7: the count wraps from zero to all ones
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_live && cnt_q == '0) |=> (&cnt_q));

  // R8: no tick, no change
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick_en && !stop_req) |=> $stable(cnt_q));

  // R9: a divisor completed on the reload tick is the one reloaded
  p_fresh_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_evt && load_req) |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/tmr_rate_channel.sv
module tmr_rate_channel
  import tmr_pkg::*;
#(
  parameter logic [1:0] CHAN_SEL = 2'd0,
  parameter int         BYTES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              ctl_we,
  input  logic              cnt_we,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              tmr_out
);

  localparam int CNT_W = BYTES * BYTE_W;

  logic             ctl_accept;
  acc_e             acc_mode;
  logic             div_commit;
  logic [CNT_W-1:0] div_value;
  logic             running;
  logic             reload_evt;

  tmr_ctrl_port #(.CHAN_SEL(CHAN_SEL)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .wr_data    (wr_data),
    .ctl_accept (ctl_accept),
    .acc_mode   (acc_mode)
  );

  tmr_byte_loader #(.CNT_W(CNT_W)) u_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_accept (ctl_accept),
    .acc_mode   (acc_mode),
    .cnt_we     (cnt_we),
    .wr_data    (wr_data),
    .div_commit (div_commit),
    .div_value  (div_value)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .stop_req   (ctl_accept),
    .load_req   (div_commit),
    .load_val   (div_value),
    .running    (running),
    .reload_evt (reload_evt),
    .tmr_out    (tmr_out)
  );

  // R1: while stopped the output is high
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> tmr_out);

  // R6: a reload always leaves the output high for a divisor above one
  p_pulse_one_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_evt && !div_commit && !tmr_out) |=> (tmr_out || !running ||
      $past(ctl_accept)) || $past(u_core.div_q) == CNT_W'(1));

endmodule

// File: tb/tmr_rate_channel_bench.sv
module tmr_rate_channel_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       ctl_we = 1'b0;
  logic       cnt_we = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tmr_out;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  tmr_rate_channel u_tmr_rate_channel (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctl_we(ctl_we),
    .cnt_we(cnt_we), .wr_data(wr_data), .tmr_out(tmr_out)
  );

  task automatic check(string tag, logic got, logic exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: tmr_out=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // Called at a negedge; the write is captured at the next posedge.
  task automatic put_ctl(logic [7:0] b);
    ctl_we = 1'b1; wr_data = b;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic put_cnt(logic [7:0] b);
    cnt_we = 1'b1; wr_data = b;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic load_lohi(int n);
    put_ctl(8'h34);
    put_cnt(8'(n));
    put_cnt(8'(n >> 8));
  endtask

  // Sample 0 is the negedge right after the loading edge. The output is
  // low when the ticks taken so far plus one is a multiple of n.
  task automatic run_check(string tag, int n, int samples, bit alt);
    int ticks = 0;
    for (int j = 0; j < samples; j++) begin
      bit exp_o;
      exp_o = ((ticks + 1) % n) != 0;
      check(tag, tmr_out, exp_o);
      tick_en = alt ? (j % 2 == 0) : 1'b1;
      @(negedge clk);
      if (tick_en) ticks++;
    end
    tick_en = 1'b1;
  endtask

  task automatic t_reset;
    tick_en = 1'b1;
    for (int j = 0; j < 4; j++) begin
      check("R1 idle after reset", tmr_out, 1'b1);
      @(negedge clk);
    end
    put_cnt(8'h02);
    put_cnt(8'h00);
    run_check("R1 default low-then-high order", 2, 8, 1'b0);
  endtask

  task automatic t_main;
    // 1193182 Hz / 1000 Hz rounded to nearest = 1193 = 0x04A9
    put_ctl(8'h34);
    put_cnt(8'hA9);
    put_cnt(8'h04);
    run_check("R4 R5 R6 paired divisor 1193", 1193, 2400, 1'b0);
  endtask

  task automatic t_single_bytes;
    put_ctl(8'h14);
    put_cnt(8'h06);
    run_check("R4 low-only divisor 6", 6, 20, 1'b0);
    put_ctl(8'h24);
    put_cnt(8'h01);
    run_check("R4 high-only divisor 256", 256, 520, 1'b0);
  endtask

  task automatic t_gated;
    load_lohi(4);
    run_check("R8 gated ticks", 4, 24, 1'b1);
  endtask

  task automatic t_zero;
    put_ctl(8'h14);
    put_cnt(8'h00);
    run_check("R7 zero divisor", 65536, 65540, 1'b0);
  endtask

  task automatic t_ignored_words;
    logic [7:0] bad [4];
    bad[0] = 8'h74; bad[1] = 8'h35; bad[2] = 8'h36; bad[3] = 8'h04;
    load_lohi(5);
    for (int j = 0; j < 25; j++) begin
      check("R2 ignored control word", tmr_out, ((j + 1) % 5) != 0);
      ctl_we = (j >= 2 && j <= 5);
      wr_data = (j >= 2 && j <= 5) ? bad[j-2] : 8'h00;
      tick_en = 1'b1;
      @(negedge clk);
    end
    ctl_we = 1'b0;
  endtask

  task automatic t_restart;
    load_lohi(5);
    for (int j = 0; j < 20; j++) begin
      check("R3 stop on new control word", tmr_out,
            (j < 8) ? (((j + 1) % 5) != 0) : 1'b1);
      cnt_we  = (j == 3);
      ctl_we  = (j == 7);
      wr_data = (j == 3) ? 8'h09 : 8'h34;
      @(negedge clk);
    end
    cnt_we = 1'b0; ctl_we = 1'b0;
    put_cnt(8'h03);
    for (int j = 0; j < 10; j++) begin
      check("R3 stopped until complete divisor", tmr_out, 1'b1);
      @(negedge clk);
    end
    put_cnt(8'h00);
    run_check("R3 byte order restarted", 3, 15, 1'b0);
  endtask

  task automatic t_reload_coincide;
    load_lohi(5);
    for (int j = 0; j < 16; j++) begin
      check("R9 divisor completed on reload tick", tmr_out,
            (j < 5) ? (((j + 1) % 5) != 0) : (((j - 4) % 3) != 0));
      cnt_we  = (j == 3 || j == 4);
      wr_data = (j == 3) ? 8'h03 : 8'h00;
      @(negedge clk);
    end
    cnt_we = 1'b0;
  endtask

  task automatic t_reload_later;
    load_lohi(5);
    for (int j = 0; j < 20; j++) begin
      check("R9 divisor waits for reload", tmr_out,
            (j < 5) ? (((j + 1) % 5) != 0) : (((j - 4) % 7) != 0));
      cnt_we  = (j == 0 || j == 1);
      wr_data = (j == 0) ? 8'h07 : 8'h00;
      @(negedge clk);
    end
    cnt_we = 1'b0;
  endtask

  task automatic t_both_strobes;
    load_lohi(5);
    for (int j = 0; j < 13; j++) begin
      check("R10 control beats count write", tmr_out,
            (j <= 2) ? (((j + 1) % 5) != 0) : 1'b1);
      ctl_we  = (j == 2);
      cnt_we  = (j == 2);
      wr_data = 8'h14;
      @(negedge clk);
    end
    ctl_we = 1'b0; cnt_we = 1'b0;
    put_cnt(8'h04);
    run_check("R10 low-only after joint write", 4, 12, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 output high in reset", tmr_out, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_main();
    t_single_bytes();
    t_gated();
    t_ignored_words();
    t_restart();
    t_reload_coincide();
    t_reload_later();
    t_both_strobes();
    t_zero();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule